// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic-logic unit for a simple processor datapath. Its width comes from a parameter, 32 bits by default. It is built from identical one-bit slices. The slices are chained carry to carry, so the adder is a ripple-carry adder. Each slice forms bitwise AND and OR of its operand bits. It also forms a full-adder sum. A small selector then picks one of these or a "less" input as the slice's result bit.

The 4-bit control word has three fields, from the top bit down:
- an operand-A invert bit;
- a negate bit;
- a 2-bit selector.

The negate bit both inverts operand B and sets the carry into bit 0. This turns addition into subtraction. Inverting both operands and selecting AND gives NOR. For the signed compare, the top slice gives the sign of A-B, corrected for overflow. That bit is fed back to the "less" input of bit 0, and all other "less" inputs are held at 0.

The block also reports a zero flag over the whole result, which is used for equality tests by subtraction. It reports a signed overflow flag for add and subtract.

Top module: `ripple_alu`

## Requirements
- R1: Code 4'b0000 gives result = a AND b.
- R2: Code 4'b0001 gives result = a OR b.
- R3: Code 4'b1100 gives result = NOT(a OR b).
- R4: Code 4'b0010 gives result = (a + b) modulo 2^32; the carry out of bit 31 is dropped.
- R5: Code 4'b0110 gives result = (a - b) modulo 2^32.
- R6: Code 4'b0111 gives result = 1 when a < b as signed two's-complement numbers, otherwise 0; bits 31..1 are always 0, and the answer stays correct when a - b overflows.
- R7: zero is 1 exactly when all 32 result bits are 0, whatever the operation; subtracting equal operands therefore sets it.
- R8: For add (4'b0010), overflow is 1 exactly when a and b have the same sign and the sum's bit 31 differs from it; operands of opposite sign never overflow.
- R9: For subtract (4'b0110), overflow is 1 exactly when a and b differ in sign and the difference's bit 31 differs from a's bit 31.
- R10: For AND, OR, NOR and set-less-than, overflow is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | {A-invert, negate, selector[1:0]} operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The built-in checks assume that ctrl_i holds one of the six listed codes whenever an operation-specific property is tested. Codes outside that set are allowed, but nothing is claimed about them. The checks also assume the operands are settled two-state values. The bench only ever drives the six listed codes, picking one at random for each vector. Operands are drawn at random and mixed with directed extremes: the most negative and most positive values, all ones, zero, and equal pairs. These extremes push the sign, overflow and zero paths through their boundaries.

// File: rtl/ripple_alu_pkg.sv
package ripple_alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    typedef struct packed {
        logic a_inv;
        logic b_neg;
        sel_e sel;
    } ctrl_t;

    localparam logic [3:0] CODE_AND = 4'b0000;
    localparam logic [3:0] CODE_OR  = 4'b0001;
    localparam logic [3:0] CODE_ADD = 4'b0010;
    localparam logic [3:0] CODE_SUB = 4'b0110;
    localparam logic [3:0] CODE_SLT = 4'b0111;
    localparam logic [3:0] CODE_NOR = 4'b1100;

    function automatic ctrl_t decode_ctrl(input logic [3:0] code);
        return ctrl_t'(code);
    endfunction

    function automatic logic is_arith(input ctrl_t c);
        return c.sel == SEL_SUM;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import ripple_alu_pkg::*;
#(
    parameter bit IS_MSB = 1'b0
) (
    input  logic a_i,
    input  logic b_i,
    input  logic ainv_i,
    input  logic bneg_i,
    input  logic carry_i,
    input  logic less_i,
    input  sel_e sel_i,
    output logic res_o,
    output logic carry_o,
    output logic set_o,
    output logic ovf_o
);
    logic a_eff;
    logic b_eff;
    logic sum;

    assign a_eff   = a_i ^ ainv_i;
    assign b_eff   = b_i ^ bneg_i;
    assign sum     = a_eff ^ b_eff ^ carry_i;
    assign carry_o = (a_eff & b_eff) | (carry_i & (a_eff ^ b_eff));

    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = a_eff & b_eff;
            SEL_OR:   res_o = a_eff | b_eff;
            SEL_SUM:  res_o = sum;
            default:  res_o = less_i;
        endcase
    end

    generate
        if (IS_MSB) begin : g_msb
            // carry into the sign bit differing from carry out marks overflow
            assign ovf_o = carry_i ^ carry_o;
            // corrected sign of the difference for the signed compare
            assign set_o = sum ^ ovf_o;
        end else begin : g_body
            assign ovf_o = 1'b0;
            assign set_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             zero_o
);
    assign zero_o = ~|value_i;
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ripple_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       ctrl_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             overflow_o
);
    localparam int MSB = WIDTH - 1;

    ctrl_t ctl;
    logic  msb_set;
    logic  msb_ovf;

    assign ctl = decode_ctrl(ctrl_i);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic cin_w;
            logic cout_w;
            logic less_w;
            logic set_w;
            logic ovf_w;
            logic res_w;

            if (i == 0) begin : g_first
                assign cin_w  = ctl.b_neg;
                assign less_w = msb_set;
            end else begin : g_next
                assign cin_w  = g_bit[i-1].cout_w;
                assign less_w = 1'b0;
            end

            alu_bit_slice #(
                .IS_MSB (i == MSB)
            ) u_slice (
                .a_i     (a_i[i]),
                .b_i     (b_i[i]),
                .ainv_i  (ctl.a_inv),
                .bneg_i  (ctl.b_neg),
                .carry_i (cin_w),
                .less_i  (less_w),
                .sel_i   (ctl.sel),
                .res_o   (res_w),
                .carry_o (cout_w),
                .set_o   (set_w),
                .ovf_o   (ovf_w)
            );

            assign result_o[i] = res_w;

            if (i == MSB) begin : g_top
                assign msb_set = set_w;
                assign msb_ovf = ovf_w;
            end
        end
    endgenerate

    assign overflow_o = msb_ovf & is_arith(ctl);

    alu_zero_detect #(
        .WIDTH (WIDTH)
    ) u_zero (
        .value_i (result_o),
        .zero_o  (zero_o)
    );

    always_comb begin
        if (ctrl_i == CODE_ADD) begin
            assert_add_sum_R4: assert (result_o == a_i + b_i)
                else $error("ripple sum differs from a+b");
            if (a_i[MSB] != b_i[MSB])
                assert_opposite_add_R8: assert (!overflow_o)
                    else $error("overflow on opposite-sign add");
        end
        if (ctrl_i == CODE_SUB && a_i == b_i)
            assert_equal_sub_zero_R7: assert (zero_o)
                else $error("equal subtract did not flag zero");
        if (ctrl_i == CODE_SLT)
            assert_slt_upper_R6: assert (result_o[MSB:1] == '0)
                else $error("compare result has upper bits set");
        if (ctrl_i == CODE_AND || ctrl_i == CODE_OR || ctrl_i == CODE_NOR || ctrl_i == CODE_SLT)
            assert_no_overflow_R10: assert (!overflow_o)
                else $error("overflow on non-arith op");
    end

endmodule

// File: tb/ripple_alu_test.sv
module ripple_alu_test;
    import ripple_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [3:0]  ctrl;
    logic [31:0] result;
    logic        zero, overflow;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ripple_alu #(.WIDTH(32)) uut (
        .a_i (a), .b_i (b), .ctrl_i (ctrl),
        .result_o (result), .zero_o (zero), .overflow_o (overflow)
    );

    function automatic logic [31:0] exp_result(logic [31:0] x, logic [31:0] y, logic [3:0] c);
        case (c)
            CODE_AND: return x & y;
            CODE_OR:  return x | y;
            CODE_NOR: return ~(x | y);
            CODE_ADD: return x + y;
            CODE_SUB: return x - y;
            default:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(logic [31:0] x, logic [31:0] y, logic [3:0] c);
        logic [31:0] s;
        if (c == CODE_ADD) begin
            s = x + y;
            return (x[31] == y[31]) && (s[31] != x[31]);
        end
        if (c == CODE_SUB) begin
            s = x - y;
            return (x[31] != y[31]) && (s[31] != x[31]);
        end
        return 1'b0;
    endfunction

    function automatic string req_of(logic [3:0] c);
        case (c)
            CODE_AND: return "R1";
            CODE_OR:  return "R2";
            CODE_NOR: return "R3";
            CODE_ADD: return "R4";
            CODE_SUB: return "R5";
            default:  return "R6";
        endcase
    endfunction

    task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c);
        logic [31:0] er;
        logic        eo;
        @(posedge clk);
        a = x; b = y; ctrl = c;
        @(negedge clk);
        er = exp_result(x, y, c);
        eo = exp_ovf(x, y, c);
        checks++;
        if (result !== er) begin
            errors++;
            $display("FAIL %s result a=%h b=%h ctrl=%b actual=%h expected=%h", req_of(c), x, y, c, result, er);
        end
        checks++;
        if (zero !== (er == 32'd0)) begin
            errors++;
            $display("FAIL R7 zero a=%h b=%h ctrl=%b actual=%b expected=%b", x, y, c, zero, er == 32'd0);
        end
        checks++;
        if (overflow !== eo) begin
            errors++;
            $display("FAIL %s overflow a=%h b=%h ctrl=%b actual=%b expected=%b",
                     (c == CODE_ADD) ? "R8" : (c == CODE_SUB) ? "R9" : "R10", x, y, c, overflow, eo);
        end
    endtask

    initial begin
        #200000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] codes [6];
        codes[0] = CODE_AND; codes[1] = CODE_OR;  codes[2] = CODE_NOR;
        codes[3] = CODE_ADD; codes[4] = CODE_SUB; codes[5] = CODE_SLT;
        a = '0; b = '0; ctrl = CODE_AND;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset-like idle state: AND of zeros gives zero result, zero flag set
        run(32'h0, 32'h0, CODE_AND);
        // R1 R2 R3 directed
        run(32'hF0F0_A5A5, 32'hFF00_0F0F, CODE_AND);
        run(32'hF0F0_A5A5, 32'hFF00_0F0F, CODE_OR);
        run(32'h0000_0000, 32'h0000_0000, CODE_NOR);
        run(32'hFFFF_FFFF, 32'h0000_0001, CODE_NOR);
        // R4 R8 add corners
        run(32'h7FFF_FFFF, 32'h0000_0001, CODE_ADD);
        run(32'h8000_0000, 32'h8000_0000, CODE_ADD);
        run(32'hFFFF_FFFF, 32'h0000_0001, CODE_ADD);
        run(32'h7FFF_FFFF, 32'h8000_0000, CODE_ADD);
        // R5 R9 R7 subtract corners
        run(32'h1234_5678, 32'h1234_5678, CODE_SUB);
        run(32'h8000_0000, 32'h0000_0001, CODE_SUB);
        run(32'h7FFF_FFFF, 32'hFFFF_FFFF, CODE_SUB);
        run(32'h0000_0000, 32'h0000_0001, CODE_SUB);
        // R6 compare, including overflowing differences
        run(32'h8000_0000, 32'h7FFF_FFFF, CODE_SLT);
        run(32'h7FFF_FFFF, 32'h8000_0000, CODE_SLT);
        run(32'hFFFF_FFFF, 32'h0000_0000, CODE_SLT);
        run(32'h0000_0005, 32'h0000_0005, CODE_SLT);
        run(32'h0000_0004, 32'h0000_0005, CODE_SLT);
        // random mix
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] x, y;
            x = $urandom();
            y = ($urandom_range(0, 7) == 0) ? x : $urandom();
            if ($urandom_range(0, 9) == 0) x = {x[31], 31'h0};
            run(x, y, codes[$urandom_range(0, 5)]);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule